// File: doc/BRIEF.md
# Two-Level Interrupt Context Controller

This block sits beside a simple in-order processor pipeline and decides when exception requests turn into interrupts. It holds a three-bit machine state register with an external enable, a critical enable and a debug enable. It also keeps two independent context slots, one for ordinary (noncritical) interrupts and one for critical interrupts. When an interrupt is accepted, the address of the next instruction and the current state register go into the matching slot. The state register is then masked and the pipeline is redirected to a handler address, which is a writable vector base plus a fixed per-cause offset.

Two return strobes, one per slot, restore the program counter and the state register from their own slot. Because the slots are separate, a critical interrupt can preempt a running noncritical handler. The noncritical handler's saved context survives the whole critical episode. Requests that their enable bit masks are ignored. Synchronous faults reported by the pipeline are never masked.

All decisions are registered. A request, return or write that is present before a rising edge shows up on the outputs just after that edge.

Top module: `irq_ctx_ctrl`

## Requirements
- R1: While `rst` is high and after it falls, `msr` reads 3'b000 and `redir_vld` is 0 until a request or return arrives.
- R2: Causes have the indices debug=0, watchdog=1, critical input=2, program fault=3, trap=4, external=5. When several are enabled in the same cycle, the lowest index wins. On the next edge `redir_vld` is 1 and `redir_pc` = vector base + index*16.
- R3: The `msr` bits are external enable [0], critical enable [1] and debug enable [2]. An external request needs bit 0, critical input and watchdog need bit 1, and debug needs bit 2. A masked request causes no redirect and leaves the state unchanged.
- R4: Program fault and trap requests are taken whatever the `msr` value.
- R5: Taking a noncritical cause (3, 4 or 5) stores {next address, `msr`} in the noncritical slot. It clears `msr[0]` and keeps bits 1 and 2.
- R6: Taking a critical cause (0, 1 or 2) stores {next address, `msr`} in the critical slot and clears all `msr` bits. The noncritical slot is left untouched.
- R7: `ret_nc` redirects to the noncritical slot's address and loads `msr` from that slot. `ret_cr` does the same from the critical slot. If both strobes are high, `ret_cr` wins.
- R8: If an interrupt and a return fall in the same cycle, the interrupt wins. The saved address is the return's target address, not `next_pc`. The saved state is the current `msr`, and the interrupt's enable test also uses the current `msr`.
- R9: When no interrupt or return is accepted, `msr_we` loads `msr_wdata` into `msr`. `vb_we` loads the vector base, and the new base applies to interrupts from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_ext | input | 1 | Asynchronous external request (noncritical) |
| req_prog | input | 1 | Synchronous program fault from the pipeline |
| req_trap | input | 1 | Synchronous trap from the pipeline |
| req_crit | input | 1 | Critical input request |
| req_wdog | input | 1 | Watchdog request |
| req_dbg | input | 1 | Debug event |
| next_pc | input | AW | Address of the next instruction to execute |
| ret_nc | input | 1 | Noncritical return strobe |
| ret_cr | input | 1 | Critical return strobe |
| msr_we | input | 1 | Software write of the state register |
| msr_wdata | input | 3 | Data for the state register write |
| vb_we | input | 1 | Software write of the vector base |
| vb_wdata | input | AW | Data for the vector base write |
| redir_vld | output | 1 | Redirect strobe, one cycle |
| redir_pc | output | AW | Redirect target address |
| msr | output | 3 | Current state register {debug, critical, external} |

## Verification
The interesting collisions are an interrupt and a return in the same cycle, and a critical interrupt that lands while a noncritical context is still saved. Directed sequences create both cases. For a clash, an external or critical request is raised together with `ret_nc` or `ret_cr`, and a later return shows which address was saved. For preemption, an external interrupt is followed by a critical one, then a critical return and a noncritical return, which must bring back each layer's address and state. The random phase mixes requests, returns and state writes at rates that make such overlaps frequent. A bench reference model decides every expected redirect and state value.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;
  localparam int NCAUSE = 6;
  localparam int CIW    = $clog2(NCAUSE);
  localparam int MSR_W  = 3;
  localparam int EE_BIT = 0;
  localparam int CE_BIT = 1;
  localparam int DE_BIT = 2;
  // causes below this index use the critical slot
  localparam int NCRIT  = 3;

  typedef enum logic [CIW-1:0] {
    C_DBG  = 3'd0,
    C_WDOG = 3'd1,
    C_CIN  = 3'd2,
    C_PROG = 3'd3,
    C_TRAP = 3'd4,
    C_EXT  = 3'd5
  } cause_e;
endpackage

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int N  = 6,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          vld,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  gnt
);
  always_comb begin
    idx = '0;
    vld = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = IW'(i);
        vld = 1'b1;
      end
    end
  end

  always_comb begin
    gnt = '0;
    if (vld) gnt[idx] = 1'b1;
  end

  // R2: a single grant, and nothing of higher priority left pending
  always_comb begin
    p_gnt_onehot_r2: assert ($onehot0(gnt));
    p_gnt_top_r2: assert (!vld || ((req & (gnt - N'(1))) == '0));
  end
endmodule

// File: rtl/irq_save_pair.sv
module irq_save_pair #(
  parameter int AW = 32,
  parameter int MW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          save_en,
  input  logic [AW-1:0] save_pc,
  input  logic [MW-1:0] save_msr,
  output logic [AW-1:0] pc_q,
  output logic [MW-1:0] msr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      msr_q <= '0;
    end else if (save_en) begin
      pc_q  <= save_pc;
      msr_q <= save_msr;
    end
  end
endmodule

// File: rtl/irq_ctx_ctrl.sv
module irq_ctx_ctrl
  import irq_ctx_pkg::*;
#(
  parameter int          AW     = 32,
  parameter int          OFF_SH = 4,
  parameter logic [AW-1:0] VB_RST = 32'h0000_0100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_ext,
  input  logic             req_prog,
  input  logic             req_trap,
  input  logic             req_crit,
  input  logic             req_wdog,
  input  logic             req_dbg,
  input  logic [AW-1:0]    next_pc,
  input  logic             ret_nc,
  input  logic             ret_cr,
  input  logic             msr_we,
  input  logic [MSR_W-1:0] msr_wdata,
  input  logic             vb_we,
  input  logic [AW-1:0]    vb_wdata,
  output logic             redir_vld,
  output logic [AW-1:0]    redir_pc,
  output logic [MSR_W-1:0] msr
);
  logic [MSR_W-1:0]  msr_q;
  logic [AW-1:0]     vbase_q;
  logic [NCAUSE-1:0] req_en;
  logic [NCAUSE-1:0] gnt;
  logic [CIW-1:0]    cidx;
  logic              take, take_cr, take_nc;
  logic [AW-1:0]     ret_tgt;
  logic [AW-1:0]     srr_pc, csrr_pc;
  logic [MSR_W-1:0]  srr_msr, csrr_msr;

  // enable gating (R3, R4)
  always_comb begin
    req_en         = '0;
    req_en[C_DBG]  = req_dbg  & msr_q[DE_BIT];
    req_en[C_WDOG] = req_wdog & msr_q[CE_BIT];
    req_en[C_CIN]  = req_crit & msr_q[CE_BIT];
    req_en[C_PROG] = req_prog;
    req_en[C_TRAP] = req_trap;
    req_en[C_EXT]  = req_ext  & msr_q[EE_BIT];
  end

  irq_prio_arb #(.N(NCAUSE), .IW(CIW)) u_arb (
    .req (req_en),
    .vld (take),
    .idx (cidx),
    .gnt (gnt)
  );

  assign take_cr = take && (int'(cidx) < NCRIT);
  assign take_nc = take && !take_cr;

  // address the interrupted stream would have continued at (R8)
  assign ret_tgt = ret_cr ? csrr_pc : (ret_nc ? srr_pc : next_pc);

  irq_save_pair #(.AW(AW), .MW(MSR_W)) u_nc_pair (
    .clk      (clk),
    .rst      (rst),
    .save_en  (take_nc),
    .save_pc  (ret_tgt),
    .save_msr (msr_q),
    .pc_q     (srr_pc),
    .msr_q    (srr_msr)
  );

  irq_save_pair #(.AW(AW), .MW(MSR_W)) u_cr_pair (
    .clk      (clk),
    .rst      (rst),
    .save_en  (take_cr),
    .save_pc  (ret_tgt),
    .save_msr (msr_q),
    .pc_q     (csrr_pc),
    .msr_q    (csrr_msr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      msr_q     <= '0;
      vbase_q   <= VB_RST;
      redir_vld <= 1'b0;
      redir_pc  <= '0;
    end else begin
      redir_vld <= 1'b0;
      if (vb_we) vbase_q <= vb_wdata;
      if (take) begin
        redir_vld <= 1'b1;
        redir_pc  <= vbase_q + (AW'(cidx) << OFF_SH);
        if (take_cr) msr_q <= '0;
        else         msr_q <= msr_q & ~(MSR_W'(1) << EE_BIT);
      end else if (ret_cr) begin
        redir_vld <= 1'b1;
        redir_pc  <= csrr_pc;
        msr_q     <= csrr_msr;
      end else if (ret_nc) begin
        redir_vld <= 1'b1;
        redir_pc  <= srr_pc;
        msr_q     <= srr_msr;
      end else if (msr_we) begin
        msr_q <= msr_wdata;
      end
    end
  end

  assign msr = msr_q;

  p_nc_clear_ee_r5: assert property (@(posedge clk) disable iff (rst)
    take_nc |=> (!msr_q[EE_BIT] && redir_vld &&
                 msr_q[CE_BIT] == $past(msr_q[CE_BIT]) &&
                 msr_q[DE_BIT] == $past(msr_q[DE_BIT])));

  p_cr_clear_all_r6: assert property (@(posedge clk) disable iff (rst)
    take_cr |=> (msr_q == '0 && redir_vld));

  p_cr_keep_nc_r6: assert property (@(posedge clk) disable iff (rst)
    take_cr |=> ($stable(srr_pc) && $stable(srr_msr)));

  p_masked_ext_r3: assert property (@(posedge clk) disable iff (rst)
    (req_ext && !msr_q[EE_BIT] && !req_dbg && !req_wdog && !req_crit &&
     !req_prog && !req_trap && !ret_nc && !ret_cr) |=> !redir_vld);

  p_sync_taken_r4: assert property (@(posedge clk) disable iff (rst)
    (req_prog || req_trap) |=> redir_vld);

  p_ret_nc_r7: assert property (@(posedge clk) disable iff (rst)
    (ret_nc && !ret_cr && !take) |=>
      (redir_vld && redir_pc == $past(srr_pc) && msr_q == $past(srr_msr)));

  p_clash_r8: assert property (@(posedge clk) disable iff (rst)
    (take_nc && ret_cr) |=> (srr_pc == $past(csrr_pc)));
endmodule

// File: tb/tb_irq_ctx_ctrl.sv
`timescale 1ns/1ps
module tb_irq_ctx_ctrl;
  localparam int AW = 32;
  localparam int SH = 4;
  localparam logic [AW-1:0] VBR = 32'h0000_0100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic i_ext = 0, i_prog = 0, i_trap = 0, i_crit = 0, i_wdog = 0, i_dbg = 0;
  logic [AW-1:0] i_npc = '0;
  logic i_rnc = 0, i_rcr = 0, i_mwe = 0, i_vwe = 0;
  logic [2:0] i_mwd = '0;
  logic [AW-1:0] i_vwd = '0;
  logic o_vld;
  logic [AW-1:0] o_pc;
  logic [2:0] o_msr;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // reference state
  logic [2:0]    m_msr, m_s1, m_c1;
  logic [AW-1:0] m_s0, m_c0, m_vb, m_pc;
  logic          m_vld;

  always #2 clk = ~clk;

  irq_ctx_ctrl #(.AW(AW), .OFF_SH(SH), .VB_RST(VBR)) dut (
    .clk(clk), .rst(rst),
    .req_ext(i_ext), .req_prog(i_prog), .req_trap(i_trap),
    .req_crit(i_crit), .req_wdog(i_wdog), .req_dbg(i_dbg),
    .next_pc(i_npc), .ret_nc(i_rnc), .ret_cr(i_rcr),
    .msr_we(i_mwe), .msr_wdata(i_mwd), .vb_we(i_vwe), .vb_wdata(i_vwd),
    .redir_vld(o_vld), .redir_pc(o_pc), .msr(o_msr)
  );

  task automatic model_reset();
    m_msr = '0; m_s0 = '0; m_s1 = '0; m_c0 = '0; m_c1 = '0;
    m_vb = VBR; m_vld = 0; m_pc = '0;
  endtask

  // highest priority enabled cause per R2/R3/R4, -1 if none
  function automatic int pick(input logic [2:0] s);
    if (i_dbg && s[2])            return 0;
    if (i_wdog && s[1])           return 1;
    if (i_crit && s[1])           return 2;
    if (i_prog)                   return 3;
    if (i_trap)                   return 4;
    if (i_ext && s[0])            return 5;
    return -1;
  endfunction

  task automatic model_step();
    int c;
    logic [AW-1:0] tgt;
    c   = pick(m_msr);
    tgt = i_rcr ? m_c0 : (i_rnc ? m_s0 : i_npc);
    m_vld = 0;
    if (c >= 0) begin
      m_vld = 1;
      m_pc  = m_vb + AW'(c * 16);
      if (c < 3) begin
        m_c0 = tgt; m_c1 = m_msr; m_msr = 3'b000;
      end else begin
        m_s0 = tgt; m_s1 = m_msr; m_msr = {m_msr[2:1], 1'b0};
      end
    end else if (i_rcr) begin
      m_vld = 1; m_pc = m_c0; m_msr = m_c1;
    end else if (i_rnc) begin
      m_vld = 1; m_pc = m_s0; m_msr = m_s1;
    end else if (i_mwe) begin
      m_msr = i_mwd;
    end
    if (i_vwe) m_vb = i_vwd;
  endtask

  task automatic idle();
    i_ext = 0; i_prog = 0; i_trap = 0; i_crit = 0; i_wdog = 0; i_dbg = 0;
    i_rnc = 0; i_rcr = 0; i_mwe = 0; i_vwe = 0;
  endtask

  // apply current inputs for one edge, then compare
  task automatic cyc(input string lbl);
    @(posedge clk);
    model_step();
    #1;
    n_chk++;
    if (o_vld !== m_vld || o_msr !== m_msr || (m_vld && o_pc !== m_pc)) begin
      n_err++;
      $display("FAIL %s: vld=%0b pc=%h msr=%b expected vld=%0b pc=%h msr=%b",
               lbl, o_vld, o_pc, o_msr, m_vld, m_pc, m_msr);
    end
    @(negedge clk);
    idle();
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset value held during reset
    n_chk++;
    if (o_vld !== 1'b0 || o_msr !== 3'b000) begin
      n_err++;
      $display("FAIL R1: vld=%0b msr=%b expected vld=0 msr=000", o_vld, o_msr);
    end
    rst = 0;
    cyc("R1 idle after reset");

    // R3: every masked request ignored with msr=000
    i_ext = 1; i_crit = 1; i_wdog = 1; i_dbg = 1; cyc("R3 all masked");
    // R9: software write of msr
    i_mwe = 1; i_mwd = 3'b111; cyc("R9 msr write");
    // R5: external taken, ee cleared
    i_ext = 1; i_npc = 32'h0000_4000; cyc("R5 ext taken");
    // R3: ext now masked by ee=0
    i_ext = 1; cyc("R3 ext masked");
    // R6: critical input preempts, nc slot kept
    i_crit = 1; i_npc = 32'h0000_5550; cyc("R6 crit preempt");
    // R4: program fault with msr=000
    i_prog = 1; i_npc = 32'h0000_6660; cyc("R4 prog unmasked");
    // R7: both returns, critical wins
    i_rcr = 1; i_rnc = 1; cyc("R7 ret_cr priority");
    i_rnc = 1; cyc("R7 ret_nc restore");
    // R2: all causes at once, debug wins
    i_mwe = 1; i_mwd = 3'b111; cyc("R9 msr write");
    i_dbg = 1; i_wdog = 1; i_crit = 1; i_prog = 1; i_trap = 1; i_ext = 1;
    cyc("R2 debug first");
    i_mwe = 1; i_mwd = 3'b011; cyc("R9 msr write");
    i_wdog = 1; i_crit = 1; i_dbg = 1; cyc("R2 watchdog over crit, dbg masked");
    i_mwe = 1; i_mwd = 3'b001; cyc("R9 msr write");
    i_trap = 1; i_ext = 1; cyc("R2 trap over ext");
    // R8: return and interrupt together
    i_mwe = 1; i_mwd = 3'b111; cyc("R9 msr write");
    i_ext = 1; i_rcr = 1; i_npc = 32'h0000_7770; cyc("R8 ext beats ret_cr");
    i_rnc = 1; cyc("R8 saved target via ret_nc");
    i_crit = 1; i_rnc = 1; cyc("R8 crit beats ret_nc");
    i_rcr = 1; cyc("R8 saved target via ret_cr");
    // R9: vector base write takes effect the next cycle
    i_vwe = 1; i_vwd = 32'h0002_0000; i_prog = 1; cyc("R9 old base same cycle");
    i_trap = 1; cyc("R9 new base");

    // random phase
    for (int k = 0; k < 3000; k++) begin
      i_ext  = ($urandom % 8)  == 0;
      i_prog = ($urandom % 20) == 0;
      i_trap = ($urandom % 20) == 0;
      i_crit = ($urandom % 12) == 0;
      i_wdog = ($urandom % 16) == 0;
      i_dbg  = ($urandom % 16) == 0;
      i_rnc  = ($urandom % 8)  == 0;
      i_rcr  = ($urandom % 12) == 0;
      i_mwe  = ($urandom % 5)  == 0;
      i_mwd  = 3'($urandom);
      i_vwe  = ($urandom % 60) == 0;
      i_vwd  = {$urandom} & 32'hFFFF_FF00;
      i_npc  = {$urandom} & 32'hFFFF_FFFC;
      cyc("R2-random mix");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule